// File: doc/BRIEF.md
# Branch Resolution and Target Unit

This block resolves one branch instruction per cycle for a 32-bit core whose instructions are 32-bit words on word boundaries. The caller presents the instruction word, the address of that instruction, the condition register, the count register and the link register, together with a form code. The form code picks one of four forms: immediate (24-bit displacement), conditional displacement (14-bit displacement), branch to the link register, or branch to the count register. One cycle later the block reports whether the branch is taken, the next fetch address, a new count value with its write enable, and a return address with its write enable.

Instruction bits are numbered 0 (most significant) to 31, so bit k is `insn_i[31-k]`. For every form the options field sits in bits 6-10 and the condition-bit index in bits 11-15. The immediate form does not use these two fields. Bit 30 chooses absolute or relative targeting, and bit 31 asks for a link write. The opcode bits 0-5 are not decoded, because `form_i` selects the form.

Top module: `branch_unit`

## Requirements
- R1: While reset is asserted, and after it, with no request yet presented, `valid_o`, `taken_o`, `ctr_we_o`, `lr_we_o` and `invalid_o` are all 0.
- R2: Immediate form (`form_i`=0): the branch is always taken. The target is bits 6-29 with two zero bits appended and the result sign-extended to 32 bits. When bit 30 is 1 this value alone is the target. When bit 30 is 0 the instruction address is added to it. Results appear on the outputs on the clock edge after the edge that captures the request.
- R3: Conditional displacement form (`form_i`=1): the target is bits 16-29 with two zero bits appended and sign-extended, then made absolute or relative by bit 30 as in R2.
- R4: When the options-field bit of weight 4 (instruction bit 8) is 0 in a non-immediate form, `ctr_we_o`=1 and `ctr_o`=`ctr_i`-1 (modulo 2^32), whether or not the branch is taken. Otherwise `ctr_we_o`=0.
- R5: With a decrement, the weight-2 options bit selects the count test on the decremented value. A 1 needs the value to be zero and a 0 needs it to be non-zero. A count of 0 wraps to all ones, which is non-zero.
- R6: When the weight-16 options bit is 0, the branch also needs condition bit `cr_i[31-idx]` (idx from bits 11-15) to equal the weight-8 options bit. When the weight-16 bit is 1 the condition is ignored. With no decrement and an ignored condition the branch is always taken.
- R7: When bit 31 is 1, `lr_we_o`=1 and `lr_o` = instruction address + 4, taken or not.
- R8: Register forms (`form_i`=2 link, 3 count) target `lr_i` or `ctr_i` with bits 1:0 cleared. Bit 30 has no effect.
- R9: A not-taken branch gives `next_pc_o` = instruction address + 4. Every `next_pc_o` has bits 1:0 equal to 0.
- R10: Count-register form with a decrement requested sets `invalid_o`=1, `taken_o`=0, `ctr_we_o`=0, `lr_we_o`=0 and `next_pc_o` = address + 4.
- R11: A cycle with `valid_i`=0 gives `valid_o`=0 with `taken_o`, `ctr_we_o`, `lr_we_o` and `invalid_o` all 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request present this cycle |
| form_i | input | 2 | 0 immediate, 1 conditional displacement, 2 to link, 3 to count |
| insn_i | input | 32 | Branch instruction word |
| pc_i | input | 32 | Address of the branch instruction |
| cr_i | input | 32 | Condition register |
| ctr_i | input | 32 | Count register |
| lr_i | input | 32 | Link register |
| valid_o | output | 1 | Result present |
| taken_o | output | 1 | Branch taken |
| next_pc_o | output | 32 | Next fetch address |
| ctr_we_o | output | 1 | Count register write enable |
| ctr_o | output | 32 | New count value |
| lr_we_o | output | 1 | Link register write enable |
| lr_o | output | 32 | Return address |
| invalid_o | output | 1 | Invalid form flagged |

## Verification
The bench tests the count test on the value after the decrement. A count of 1 must fail a non-zero test, and a count of 0 must wrap and pass it. A design that tested the old value would get both cases backwards. The bench also checks that the decrement and the link write happen on not-taken branches, which a design gating them with the taken result would drop. It checks that negative displacements sign-extend in both the relative and absolute modes and that the condition index counts from the most significant bit. It checks that the count-register form with a decrement writes nothing, even when the link bit is 1.

// File: rtl/branch_pkg.sv
package branch_pkg;
  typedef enum logic [1:0] {
    FORM_IMM      = 2'd0,
    FORM_DISP     = 2'd1,
    FORM_TO_LINK  = 2'd2,
    FORM_TO_COUNT = 2'd3
  } br_form_e;
endpackage

// File: rtl/bu_cond_eval.sv
module bu_cond_eval #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned CR_W = 32,
  localparam int unsigned IDX_W = $clog2(CR_W)
) (
  input  logic [4:0]       opt_i,
  input  logic [IDX_W-1:0] cbit_i,
  input  logic [CR_W-1:0]  cr_i,
  input  logic [XLEN-1:0]  ctr_i,
  output logic             dec_req_o,
  output logic [XLEN-1:0]  ctr_next_o,
  output logic             pass_o
);
  logic [IDX_W-1:0] cr_pos;
  logic ctr_zero, ctr_ok, cond_ok;

  assign dec_req_o  = ~opt_i[2];
  assign ctr_next_o = ctr_i - XLEN'(1);
  assign ctr_zero   = (ctr_next_o == '0);
  // bit 0 of the index is the MSB of cr_i
  assign cr_pos     = IDX_W'(CR_W - 1) - cbit_i;
  assign ctr_ok     = opt_i[2] | (ctr_zero == opt_i[1]);
  assign cond_ok    = opt_i[4] | (cr_i[cr_pos] == opt_i[3]);
  assign pass_o     = ctr_ok & cond_ok;
endmodule

// File: rtl/bu_target_gen.sv
module bu_target_gen
  import branch_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  br_form_e        form_i,
  input  logic [25:0]     field_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] lr_i,
  input  logic [XLEN-1:0] ctr_i,
  output logic [XLEN-1:0] target_o,
  output logic [XLEN-1:0] seq_o
);
  localparam logic [XLEN-1:0] ALIGN_MASK = ~XLEN'(3);

  logic [XLEN-1:0] pc_al, long_ext, short_ext, disp;
  logic abs_mode;

  assign pc_al     = pc_i & ALIGN_MASK;
  assign seq_o     = pc_al + XLEN'(4);
  assign long_ext  = {{(XLEN-26){field_i[25]}}, field_i[25:2], 2'b00};
  assign short_ext = {{(XLEN-16){field_i[15]}}, field_i[15:2], 2'b00};
  assign abs_mode  = field_i[1];
  assign disp      = (form_i == FORM_IMM) ? long_ext : short_ext;

  always_comb begin
    unique case (form_i)
      FORM_TO_LINK:  target_o = lr_i & ALIGN_MASK;
      FORM_TO_COUNT: target_o = ctr_i & ALIGN_MASK;
      default:       target_o = abs_mode ? disp : pc_al + disp;
    endcase
  end
endmodule

// File: rtl/branch_unit.sv
module branch_unit
  import branch_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [1:0]      form_i,
  input  logic [31:0]     insn_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [31:0]     cr_i,
  input  logic [XLEN-1:0] ctr_i,
  input  logic [XLEN-1:0] lr_i,
  output logic            valid_o,
  output logic            taken_o,
  output logic [XLEN-1:0] next_pc_o,
  output logic            ctr_we_o,
  output logic [XLEN-1:0] ctr_o,
  output logic            lr_we_o,
  output logic [XLEN-1:0] lr_o,
  output logic            invalid_o
);
  br_form_e        form;
  logic [4:0]      opt;
  logic [4:0]      cbit;
  logic            lk;
  logic            dec_req, pass, bad, take;
  logic [XLEN-1:0] ctr_next, target, seq;
  logic            unused_opc;

  assign form       = br_form_e'(form_i);
  assign opt        = insn_i[25:21];
  assign cbit       = insn_i[20:16];
  assign lk         = insn_i[0];
  assign unused_opc = ^insn_i[31:26];

  bu_cond_eval #(.XLEN(XLEN), .CR_W(32)) u_cond (
    .opt_i      (opt),
    .cbit_i     (cbit),
    .cr_i       (cr_i),
    .ctr_i      (ctr_i),
    .dec_req_o  (dec_req),
    .ctr_next_o (ctr_next),
    .pass_o     (pass)
  );

  bu_target_gen #(.XLEN(XLEN)) u_tgt (
    .form_i   (form),
    .field_i  (insn_i[25:0]),
    .pc_i     (pc_i),
    .lr_i     (lr_i),
    .ctr_i    (ctr_i),
    .target_o (target),
    .seq_o    (seq)
  );

  // count-target form cannot also consume the count
  assign bad  = (form == FORM_TO_COUNT) & dec_req;
  assign take = (form == FORM_IMM) | (pass & ~bad);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      taken_o   <= 1'b0;
      next_pc_o <= '0;
      ctr_we_o  <= 1'b0;
      ctr_o     <= '0;
      lr_we_o   <= 1'b0;
      lr_o      <= '0;
      invalid_o <= 1'b0;
    end else begin
      valid_o   <= valid_i;
      taken_o   <= valid_i & take;
      ctr_we_o  <= valid_i & (form != FORM_IMM) & dec_req & ~bad;
      lr_we_o   <= valid_i & lk & ~bad;
      invalid_o <= valid_i & bad;
      if (valid_i) begin
        next_pc_o <= take ? target : seq;
        ctr_o     <= ctr_next;
        lr_o      <= seq;
      end
    end
  end

  // R9
  next_pc_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> next_pc_o[1:0] == 2'b00);

  // R10
  invalid_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> !taken_o && !ctr_we_o && !lr_we_o);

  // R4
  ctr_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctr_we_o |-> ctr_o == $past(ctr_i) - XLEN'(1));

  // R7
  lr_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lr_we_o |-> lr_o == ($past(pc_i) & ~XLEN'(3)) + XLEN'(4));

  // R9
  fallthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !taken_o) |-> next_pc_o == ($past(pc_i) & ~XLEN'(3)) + XLEN'(4));

  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !taken_o && !ctr_we_o && !lr_we_o && !invalid_o);
endmodule

// File: tb/tb_branch_unit.sv
module tb_branch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  form_i = '0;
  logic [31:0] insn_i = '0, pc_i = '0, cr_i = '0, ctr_i = '0, lr_i = '0;
  logic        valid_o, taken_o, ctr_we_o, lr_we_o, invalid_o;
  logic [31:0] next_pc_o, ctr_o, lr_o;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  branch_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .form_i(form_i),
    .insn_i(insn_i), .pc_i(pc_i), .cr_i(cr_i), .ctr_i(ctr_i), .lr_i(lr_i),
    .valid_o(valid_o), .taken_o(taken_o), .next_pc_o(next_pc_o),
    .ctr_we_o(ctr_we_o), .ctr_o(ctr_o), .lr_we_o(lr_we_o), .lr_o(lr_o),
    .invalid_o(invalid_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_imm(input logic [23:0] li, input logic aa, input logic lk);
    return {6'd18, li, aa, lk};
  endfunction

  function automatic logic [31:0] mk_bc(input logic [4:0] bo, input logic [4:0] bi,
                                        input logic [13:0] bd, input logic aa, input logic lk);
    return {6'd16, bo, bi, bd, aa, lk};
  endfunction

  // one request, outputs checked one cycle later
  task automatic run(input string req, input logic [1:0] f, input logic [31:0] insn,
                     input logic [31:0] cr, input logic [31:0] ctr, input logic [31:0] lr,
                     input logic e_tk, input logic [31:0] e_pc, input logic e_cwe,
                     input logic [31:0] e_ctr, input logic e_lwe, input logic e_inv);
    @(negedge clk);
    valid_i = 1'b1; form_i = f; insn_i = insn; pc_i = 32'h0000_1000;
    cr_i = cr; ctr_i = ctr; lr_i = lr;
    @(negedge clk);
    valid_i = 1'b0;
    chk(req, "valid_o", 32'(valid_o), 32'd1);
    chk(req, "taken_o", 32'(taken_o), 32'(e_tk));
    chk(req, "next_pc_o", next_pc_o, e_pc);
    chk(req, "ctr_we_o", 32'(ctr_we_o), 32'(e_cwe));
    if (e_cwe) chk(req, "ctr_o", ctr_o, e_ctr);
    chk(req, "lr_we_o", 32'(lr_we_o), 32'(e_lwe));
    if (e_lwe) chk(req, "lr_o", lr_o, 32'h0000_1004);
    chk(req, "invalid_o", 32'(invalid_o), 32'(e_inv));
  endtask

  task automatic t_reset();
    chk("R1", "valid_o", 32'(valid_o), 0);
    chk("R1", "taken_o", 32'(taken_o), 0);
    chk("R1", "ctr_we_o", 32'(ctr_we_o), 0);
    chk("R1", "lr_we_o", 32'(lr_we_o), 0);
    chk("R1", "invalid_o", 32'(invalid_o), 0);
  endtask

  task automatic t_immediate();
    // R2 relative, displacement -16, with link (R7)
    run("R2", 2'd0, mk_imm(24'hFFFFFC, 1'b0, 1'b1), 0, 7, 0, 1, 32'h0000_0FF0, 0, 0, 1, 0);
    // R2 absolute, options-field bits inside the displacement must not decrement
    run("R2", 2'd0, mk_imm(24'h000040, 1'b1, 1'b0), 0, 7, 0, 1, 32'h0000_0100, 0, 0, 0, 0);
  endtask

  task automatic t_condition();
    // R6 true-test, index 2 -> cr bit 29
    run("R6", 2'd1, mk_bc(5'b01100, 5'd2, 14'h0010, 0, 0), 32'h2000_0000, 9, 0, 1, 32'h0000_1040, 0, 0, 0, 0);
    run("R6", 2'd1, mk_bc(5'b01100, 5'd2, 14'h0010, 0, 0), 32'h0000_0000, 9, 0, 0, 32'h0000_1004, 0, 0, 0, 0);
    // R3 false-test, absolute -4
    run("R3", 2'd1, mk_bc(5'b00100, 5'd2, 14'h3FFF, 1, 0), 32'h0000_0000, 9, 0, 1, 32'hFFFF_FFFC, 0, 0, 0, 0);
    // R6 index 31 -> cr bit 0, condition ignored when weight-16 set
    run("R6", 2'd1, mk_bc(5'b01100, 5'd31, 14'h0004, 0, 0), 32'h0000_0001, 9, 0, 1, 32'h0000_1010, 0, 0, 0, 0);
    run("R6", 2'd1, mk_bc(5'b10100, 5'd31, 14'h0004, 0, 0), 32'h0000_0000, 9, 0, 1, 32'h0000_1010, 0, 0, 0, 0);
  endtask

  task automatic t_count();
    // R4/R5 non-zero test on decremented value
    run("R5", 2'd1, mk_bc(5'b10000, 0, 14'h3FFE, 0, 0), 0, 5, 0, 1, 32'h0000_0FF8, 1, 4, 0, 0);
    run("R4", 2'd1, mk_bc(5'b10000, 0, 14'h3FFE, 0, 0), 0, 1, 0, 0, 32'h0000_1004, 1, 0, 0, 0);
    run("R5", 2'd1, mk_bc(5'b10010, 0, 14'h0002, 0, 0), 0, 1, 0, 1, 32'h0000_1008, 1, 0, 0, 0);
    // R5 wrap from 0 is non-zero
    run("R5", 2'd1, mk_bc(5'b10000, 0, 14'h0002, 0, 0), 0, 0, 0, 1, 32'h0000_1008, 1, 32'hFFFF_FFFF, 0, 0);
    // R7 count and condition combined, link written taken and not taken
    run("R7", 2'd1, mk_bc(5'b01000, 0, 14'h0008, 0, 1), 32'h8000_0000, 3, 0, 1, 32'h0000_1020, 1, 2, 1, 0);
    run("R7", 2'd1, mk_bc(5'b01000, 0, 14'h0008, 0, 1), 32'h0000_0000, 3, 0, 0, 32'h0000_1004, 1, 2, 1, 0);
    run("R4", 2'd1, mk_bc(5'b00010, 0, 14'h0008, 0, 0), 32'h0000_0000, 1, 0, 1, 32'h0000_1020, 1, 0, 0, 0);
  endtask

  task automatic t_register();
    // R8 bit 30 set but ignored
    run("R8", 2'd2, mk_bc(5'b10100, 0, 0, 1, 1), 0, 9, 32'h0000_2003, 1, 32'h0000_2000, 0, 0, 1, 0);
    run("R8", 2'd3, mk_bc(5'b10100, 0, 0, 1, 0), 0, 32'h0000_3006, 0, 1, 32'h0000_3004, 0, 0, 0, 0);
    run("R9", 2'd2, mk_bc(5'b01100, 0, 0, 0, 0), 0, 9, 32'h0000_2000, 0, 32'h0000_1004, 0, 0, 0, 0);
  endtask

  task automatic t_invalid();
    run("R10", 2'd3, mk_bc(5'b10000, 0, 0, 0, 1), 0, 32'h0000_3006, 0, 0, 32'h0000_1004, 0, 0, 0, 1);
  endtask

  task automatic t_idle();
    @(negedge clk);
    valid_i = 1'b0; form_i = 2'd1; insn_i = mk_bc(5'b10000, 0, 4, 0, 1); ctr_i = 5;
    @(negedge clk);
    chk("R11", "valid_o", 32'(valid_o), 0);
    chk("R11", "ctr_we_o", 32'(ctr_we_o), 0);
    chk("R11", "lr_we_o", 32'(lr_we_o), 0);
    chk("R11", "taken_o", 32'(taken_o), 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_immediate();
        t_condition();
        t_count();
        t_register();
        t_invalid();
        t_idle();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule